// File: doc/BRIEF.md
# DMA Channel Request and Completion Controller

This block is the control logic of a single DMA channel. It watches one request source and raises a request to the channel arbiter. The source is either an external pin or one of sixteen peripheral interrupt lines. It counts transfer units as the bus engine reports them done. At the boundaries that the transfer mode defines, it sends a one-cycle clear pulse back to the peripheral that asked.

A 16-bit transfer count runs down by one for every completed unit. When the count reaches zero, the channel posts a normal-end code. With reload off, it then disables itself. With reload on, it restores the starting count and stays armed.

Address generation and bus cycles belong to other blocks. This controller only decides when a transfer unit is wanted and what happens once it finishes.

Top module: `dcc_chan_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `xfer_req` is 0, `irq_clr` is 0, `end_code` is 00 (none) and `chan_en` is 0.
- R2: A one-cycle `chan_en_set` pulse does four things at the next clock edge. It sets `chan_en`, loads `cnt_init` as the transfer count (0 means 65536), returns `end_code` to 00 and empties the burst and held-request state.
- R3: An edge-type pin source is used when `src_sel[4]`=0, `cfg_level`=0 and `mode` is not demand. `pin_req` passes through a two-flop synchroniser, and its rising edge is held as a pending request. The pending request keeps `xfer_req` high until the mode's clear point. For block/step that is one completed unit. For burst it is `burst_len` completed units.
- R4: A level-type source keeps `xfer_req` asserted while the request line is high. Level-type sources are the pin with `cfg_level`=1, the pin in demand mode, and a peripheral line. Once `xfer_req` is high, it stays high until the unit completes, even if the request line drops meanwhile.
- R5: `src_sel[4]`=1 selects peripheral line `periph_irq[src_sel[3:0]]` as a level request. The other peripheral lines have no effect.
- R6: In block/step mode (`mode`=00, and 11 behaves the same) with a peripheral source, `irq_clr` carries a one-cycle pulse on bit `src_sel[3:0]` only, after each completed unit.
- R7: In burst mode (`mode`=01) with a peripheral source, the one-cycle clear pulse follows every `burst_len`-th completed unit. A `burst_len` of 0 counts as 1.
- R8: In demand mode (`mode`=10), only the pin is accepted, and it is always treated as a level request. Peripheral lines raise no request, and `irq_clr` stays 0.
- R9: When the unit that brings the count to 0 completes with `reload_en`=0, several things happen. `end_code` becomes 01 (normal end), `chan_en` drops, and `xfer_req` stays 0 whatever the request inputs do until the next `chan_en_set`.
- R10: When that unit completes with `reload_en`=1, `end_code` becomes 01 and `chan_en` stays 1. The count is reloaded from `cnt_init`, any held edge request is discarded, and the channel waits for new requests.
- R11: A completed unit is counted only when `unit_done` and `xfer_req` are both high at the clock edge. Otherwise `unit_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en_set | input | 1 | Pulse: arm the channel and load the count |
| cnt_init | input | 16 | Starting transfer count (0 = 65536) |
| reload_en | input | 1 | Reload the count at terminal instead of disabling |
| mode | input | 2 | 00 block/step, 01 burst, 10 demand, 11 as block |
| src_sel | input | 5 | Bit 4: 1 = peripheral, bits 3:0 its index |
| cfg_level | input | 1 | Pin source: 1 = level, 0 = rising edge |
| burst_len | input | 8 | Units per burst before a clear (0 = 1) |
| pin_req | input | 1 | Asynchronous external request pin |
| periph_irq | input | 16 | Peripheral interrupt lines, synchronous, level |
| unit_done | input | 1 | Bus engine reports a transfer unit complete |
| xfer_req | output | 1 | Request to the channel arbiter |
| irq_clr | output | 16 | One-hot clear pulse to the requesting peripheral |
| end_code | output | 2 | 00 none, 01 normal end |
| chan_en | output | 1 | Channel enabled |

## Verification
A peripheral line sampled at one clock edge is reflected in `xfer_req` after that edge. A pin level or pin rising edge sampled at edge k is reflected after edge k+2, because of the two synchroniser flops. A `unit_done` accepted at an edge updates `irq_clr`, `end_code`, `chan_en`, the count and `xfer_req` at that same edge.

The bench drives inputs on falling edges. A behavioural reference model steps on each rising edge using those same inputs. The model contains those synchroniser delays, so its outputs line up cycle for cycle with the design's. All four outputs are compared on the next falling edge. Directed checks also sample on a falling edge, after the edge that should have produced the result.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_DEMAND = 2'b10,
    MODE_ALTBLK = 2'b11
  } xfer_mode_e;

  localparam logic [1:0] END_NONE   = 2'b00;
  localparam logic [1:0] END_NORMAL = 2'b01;

endpackage

// File: rtl/dcc_pin_sync.sv
module dcc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_rise
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign pin_lvl  = chain_q[STAGES-1];
  assign pin_rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/dcc_src_sel.sv
module dcc_src_sel
  import dcc_pkg::*;
#(
  parameter int SEL_W   = 5,
  localparam int IDX_W  = SEL_W - 1,
  localparam int NPERIPH = 1 << IDX_W
) (
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NPERIPH-1:0] periph_irq,
  input  logic               cfg_level,
  input  xfer_mode_e         mode_i,
  input  logic               pin_lvl,
  output logic               use_edge,
  output logic               lvl_req,
  output logic               periph_src,
  output logic [NPERIPH-1:0] clr_vec
);

  logic             demand;
  logic [IDX_W-1:0] idx;

  assign demand     = (mode_i == MODE_DEMAND);
  assign periph_src = src_sel[SEL_W-1];
  assign idx        = src_sel[IDX_W-1:0];
  assign use_edge   = ~periph_src & ~cfg_level & ~demand;

  always_comb begin
    if (periph_src) begin
      lvl_req = ~demand & periph_irq[idx];
    end else if (cfg_level || demand) begin
      lvl_req = pin_lvl;
    end else begin
      lvl_req = 1'b0;
    end
  end

  for (genvar g = 0; g < NPERIPH; g++) begin : g_dec
    assign clr_vec[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/dcc_burst_ctr.sv
module dcc_burst_ctr #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               unit_ok,
  input  logic               burst_mode,
  input  logic [BURST_W-1:0] burst_len,
  output logic               burst_end
);

  localparam int EXT_W = BURST_W + 1;

  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_d;
  logic [EXT_W-1:0]   eff_len;
  logic [EXT_W-1:0]   cnt_inc;
  logic               cnt_ce;

  assign eff_len   = (burst_len == '0) ? EXT_W'(1) : {1'b0, burst_len};
  assign cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
  assign burst_end = unit_ok & burst_mode & (cnt_inc >= eff_len);

  always_comb begin
    cnt_ce = restart | (unit_ok & burst_mode);
    if (restart || burst_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[BURST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dcc_chan_ctrl.sv
module dcc_chan_ctrl
  import dcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 5,
  parameter int BURST_W     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NPERIPH    = 1 << (SEL_W - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en_set,
  input  logic [CNT_W-1:0]   cnt_init,
  input  logic               reload_en,
  input  logic [1:0]         mode,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               cfg_level,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               pin_req,
  input  logic [NPERIPH-1:0] periph_irq,
  input  logic               unit_done,
  output logic               xfer_req,
  output logic [NPERIPH-1:0] irq_clr,
  output logic [1:0]         end_code,
  output logic               chan_en
);

  xfer_mode_e mode_i;
  assign mode_i = xfer_mode_e'(mode);

  logic pin_lvl, pin_rise;
  logic use_edge, lvl_req, periph_src;
  logic [NPERIPH-1:0] clr_vec;
  logic burst_end;

  logic               en_q, en_d;
  logic [CNT_W-1:0]   tc_q, tc_d;
  logic               tc_ce;
  logic               pend_q, pend_d;
  logic               xfer_q, xfer_d;
  logic [NPERIPH-1:0] clr_q, clr_d;
  logic [1:0]         end_q, end_d;

  logic unit_ok, term, blk_end, unit_clr, src_now;

  dcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_req),
    .pin_lvl   (pin_lvl),
    .pin_rise  (pin_rise)
  );

  dcc_src_sel #(.SEL_W(SEL_W)) u_src (
    .src_sel    (src_sel),
    .periph_irq (periph_irq),
    .cfg_level  (cfg_level),
    .mode_i     (mode_i),
    .pin_lvl    (pin_lvl),
    .use_edge   (use_edge),
    .lvl_req    (lvl_req),
    .periph_src (periph_src),
    .clr_vec    (clr_vec)
  );

  dcc_burst_ctr #(.BURST_W(BURST_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (chan_en_set | term),
    .unit_ok    (unit_ok),
    .burst_mode (mode_i == MODE_BURST),
    .burst_len  (burst_len),
    .burst_end  (burst_end)
  );

  // unit accounting
  assign unit_ok  = unit_done & xfer_q & en_q;
  assign term     = unit_ok & (tc_q == CNT_W'(1));
  assign blk_end  = unit_ok & ((mode_i == MODE_BLOCK) | (mode_i == MODE_ALTBLK));
  assign unit_clr = blk_end | burst_end;

  always_comb begin
    // enable
    if (chan_en_set)           en_d = 1'b1;
    else if (term && !reload_en) en_d = 1'b0;
    else                       en_d = en_q;

    // transfer count
    tc_ce = chan_en_set | unit_ok;
    if (chan_en_set || (term && reload_en)) tc_d = cnt_init;
    else                                    tc_d = tc_q - CNT_W'(1);

    // end code
    if (chan_en_set) end_d = END_NONE;
    else if (term)   end_d = END_NORMAL;
    else             end_d = end_q;

    // held edge request
    if (chan_en_set) pend_d = 1'b0;
    else pend_d = en_d & use_edge & (pin_rise | (pend_q & ~unit_clr & ~term));

    src_now = use_edge ? pend_d : lvl_req;
    xfer_d  = en_d & ((xfer_q & ~unit_ok) | src_now);

    // peripheral clear pulse
    clr_d = (unit_clr && periph_src) ? clr_vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      xfer_q <= 1'b0;
      clr_q  <= '0;
      end_q  <= END_NONE;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      xfer_q <= xfer_d;
      clr_q  <= clr_d;
      end_q  <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
    end else if (tc_ce) begin
      tc_q <= tc_d;
    end
  end

  assign xfer_req = xfer_q;
  assign irq_clr  = clr_q;
  assign end_code = end_q;
  assign chan_en  = en_q;

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int NPERIPH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chan_en_set,
  input logic               reload_en,
  input logic [1:0]         mode,
  input logic               unit_done,
  input logic               xfer_req,
  input logic [NPERIPH-1:0] irq_clr,
  input logic [1:0]         end_code,
  input logic               chan_en
);

  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_set |=> (chan_en && end_code == 2'b00));

  a_r4_hold_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !unit_done) |=> xfer_req);

  a_r6_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clr));

  a_r6_clr_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr != '0) |-> $past(unit_done && xfer_req));

  a_r8_demand_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr != '0) |-> ($past(mode) != 2'b10));

  a_r9_end_disables: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_code[0]) && !$past(reload_en)) |-> !chan_en);

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !xfer_req);

  a_r10_reload_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(end_code[0]) && $past(reload_en)) |-> chan_en);

endmodule

bind dcc_chan_ctrl dcc_chk #(.NPERIPH(NPERIPH)) u_chk (.*);

// File: tb/sim_dcc_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dcc_chan_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en_set = 1'b0;
  logic [15:0] cnt_init = '0;
  logic        reload_en = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  src_sel = '0;
  logic        cfg_level = 1'b0;
  logic [7:0]  burst_len = 8'd1;
  logic        pin_req = 1'b0;
  logic [15:0] periph_irq = '0;
  logic        unit_done = 1'b0;
  logic        xfer_req;
  logic [15:0] irq_clr;
  logic [1:0]  end_code;
  logic        chan_en;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dcc_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chan_en_set(chan_en_set), .cnt_init(cnt_init),
    .reload_en(reload_en), .mode(mode), .src_sel(src_sel), .cfg_level(cfg_level),
    .burst_len(burst_len), .pin_req(pin_req), .periph_irq(periph_irq),
    .unit_done(unit_done), .xfer_req(xfer_req), .irq_clr(irq_clr),
    .end_code(end_code), .chan_en(chan_en)
  );

  // ---------------- behavioural reference model ----------------
  int  m_sync[$];       // synchroniser stages, oldest last
  int  m_prev;
  int  m_on, m_left, m_held, m_units, m_req, m_clr_idx, m_end;

  task automatic model_reset();
    m_sync = '{0, 0};
    m_prev = 0; m_on = 0; m_left = 0; m_held = 0; m_units = 0;
    m_req = 0; m_clr_idx = -1; m_end = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int pin_now, rise, demand, periph, edge_src, level, accepted, last, blk, brst, blen, en_next, held_next, want;
      pin_now  = m_sync[1];
      rise     = pin_now && !m_prev;
      demand   = (mode == 2'b10);
      periph   = src_sel[4];
      edge_src = !periph && !cfg_level && !demand;
      if (periph) level = demand ? 0 : periph_irq[src_sel[3:0]];
      else        level = (cfg_level || demand) ? pin_now : 0;
      accepted = unit_done && m_req && m_on;
      last     = accepted && (m_left == 1);
      blen     = (burst_len == 0) ? 1 : burst_len;
      blk      = accepted && (mode == 2'b00 || mode == 2'b11);
      brst     = accepted && (mode == 2'b01) && (m_units + 1 >= blen);
      m_clr_idx = ((blk || brst) && periph) ? int'(src_sel[3:0]) : -1;
      if (chan_en_set) begin
        en_next = 1; m_left = (cnt_init == 0) ? 65536 : cnt_init;
        m_end = 0; m_units = 0; held_next = 0;
      end else begin
        en_next = m_on;
        if (accepted) m_left = m_left - 1;
        if (last) begin
          m_end = 1; m_units = 0;
          if (reload_en) m_left = (cnt_init == 0) ? 65536 : cnt_init;
          else en_next = 0;
        end else if (accepted && mode == 2'b01) begin
          m_units = brst ? 0 : m_units + 1;
        end
        held_next = en_next && edge_src && (rise || (m_held && !(blk || brst) && !last));
      end
      want  = edge_src ? held_next : level;
      m_req = en_next && ((m_req && !accepted) || want);
      m_on  = en_next;
      m_held = held_next;
      m_prev = pin_now;
      m_sync.push_front(int'(pin_req));
      void'(m_sync.pop_back());
    end
  end

  // -------- per-cycle comparison on the falling edge --------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [15:0] exp_clr;
      exp_clr = (m_clr_idx < 0) ? 16'h0 : (16'h1 << m_clr_idx);
      vectors++;
      if (xfer_req !== m_req[0]) begin
        fails++; $display("FAIL R4 xfer_req act=%0b exp=%0b t=%0t", xfer_req, m_req[0], $time);
      end
      if (irq_clr !== exp_clr) begin
        fails++; $display("FAIL R6 irq_clr act=%h exp=%h t=%0t", irq_clr, exp_clr, $time);
      end
      if (end_code !== 2'(m_end)) begin
        fails++; $display("FAIL R9 end_code act=%b exp=%0d t=%0t", end_code, m_end, $time);
      end
      if (chan_en !== m_on[0]) begin
        fails++; $display("FAIL R10 chan_en act=%0b exp=%0b t=%0t", chan_en, m_on[0], $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm(input int count);
    @(negedge clk); cnt_init = 16'(count); chan_en_set = 1'b1;
    @(negedge clk); chan_en_set = 1'b0;
  endtask

  task automatic unit();
    @(negedge clk); unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk); pin_req = 1'b1;
    wait_n(3);
    pin_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    wait_n(3);
    // R1: reset state
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 chan_en", chan_en, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_n(2);
    chk("R1 end_code", end_code, 0);
    chk("R1 irq_clr", irq_clr, 0);

    // R2, R3: edge pin, block mode, count 3, no reload
    arm(3);
    chk("R2 chan_en", chan_en, 1);
    chk("R2 end_code", end_code, 0);
    pin_pulse();
    wait_n(4);
    chk("R3 held request", xfer_req, 1);
    unit();
    chk("R3 released after block", xfer_req, 0);
    pin_pulse(); wait_n(2); unit();
    pin_pulse(); wait_n(2); unit();
    chk("R9 end_code", end_code, 1);
    chk("R9 chan_en", chan_en, 0);
    pin_pulse(); wait_n(3);
    chk("R9 ignored after end", xfer_req, 0);

    // R11: unit_done while idle is not counted
    arm(2);
    unit(); unit(); unit();
    pin_pulse(); wait_n(2); unit();
    chk("R11 still enabled", chan_en, 1);
    pin_pulse(); wait_n(2); unit();
    chk("R11 end after two", chan_en, 0);

    // R5, R7: peripheral 3 in burst of 3
    src_sel = 5'h13; mode = 2'b01; burst_len = 8'd3;
    arm(10);
    periph_irq = 16'h0020;
    wait_n(3);
    chk("R5 other line ignored", xfer_req, 0);
    periph_irq = 16'h0009;
    wait_n(2);
    chk("R5 selected line", xfer_req, 1);
    unit(); unit(); unit(); unit(); unit(); unit();
    @(negedge clk); periph_irq = 16'h0001;
    unit();
    chk("R4 dropped after unit", xfer_req, 0);

    // R7: burst length 0 behaves as 1
    burst_len = 8'd0;
    periph_irq = 16'h0008;
    unit(); unit();
    periph_irq = 16'h0000;
    unit();

    // R3 with burst: edge pin held over two units
    src_sel = 5'h00; burst_len = 8'd2;
    arm(8);
    pin_pulse(); wait_n(2);
    unit();
    chk("R3 burst still held", xfer_req, 1);
    unit();
    chk("R3 burst released", xfer_req, 0);

    // R8, R4: demand mode
    mode = 2'b10; cfg_level = 1'b0;
    @(negedge clk); pin_req = 1'b1;
    wait_n(4);
    chk("R8 pin as level", xfer_req, 1);
    unit();
    pin_req = 1'b0;
    wait_n(3);
    chk("R4 hold until done", xfer_req, 1);
    unit();
    chk("R4 stop after unit", xfer_req, 0);
    src_sel = 5'h11; periph_irq = 16'h0002;
    wait_n(3);
    chk("R8 periph ignored", xfer_req, 0);
    periph_irq = 16'h0;

    // R10: reload with a level peripheral in block mode
    mode = 2'b00; src_sel = 5'h12; reload_en = 1'b1;
    arm(2);
    periph_irq = 16'h0004;
    wait_n(2);
    unit(); unit();
    chk("R10 end_code", end_code, 1);
    chk("R10 chan_en kept", chan_en, 1);
    unit(); unit();
    chk("R10 second pass", chan_en, 1);
    periph_irq = 16'h0;
    unit();

    // R4: level pin, block mode
    src_sel = 5'h00; cfg_level = 1'b1; reload_en = 1'b0;
    arm(4);
    @(negedge clk); pin_req = 1'b1;
    wait_n(4); pin_req = 1'b0;
    wait_n(4);
    chk("R4 level pin hold", xfer_req, 1);
    unit();
    wait_n(2);
    chk("R4 level pin stop", xfer_req, 0);

    wait_n(4);
    finish_run();
  end

endmodule